// File: doc/BRIEF.md
# Sprite Scanline Range Evaluator

This block walks a 128-entry sprite attribute table once per scanline and finds the sprites that overlap that line. It drives the attribute memory address itself. Each sprite is held on the bus for two clocks, and the X/Y word, X bit 8 and the size select are read back from an asynchronous-read attribute memory outside the block. For every sprite it checks the vertical extent against the current line and the horizontal position against the visible range. It keeps only the 7-bit indices of the sprites that pass, in a 32-entry list.

A line controller pulses `line_start` with the line number, which can be any of 0 to 255. The same scan runs on every rendered line, the last one included. After 256 clocks the block raises `done`, and the index list, the hit count and the overflow flag stay valid until the next start. Because the scan address is the live attribute-memory address, an outside write made during the scan lands on the sprite that is being evaluated.

Top module: `sev_range_eval`

## Requirements
- R1: After reset `busy`, `done` and `overflow` are 0, `hit_count` is 0 and `attr_addr` is 0.
- R2: A `line_start` sampled while idle starts a scan on the next clock. Sprites are visited in ascending order 0 to 127. `attr_addr` equals the sprite index and holds for exactly two clocks per sprite, so `busy` stays high for 256 clocks.
- R3: `done` is high for exactly one clock, beginning at the clock edge that records sprite 127 (256 clocks after the start edge), and `busy` is low while `done` is high.
- R4: A sprite is vertically in range when (line_num - Y) mod 256 is less than its selected height, so a sprite near the bottom can wrap onto the top lines.
- R5: `attr_size` = 1 selects `cfg_big_h` as the sprite's height and width, and 0 selects `cfg_small_h`.
- R6: With the 9-bit X = {attr_x_hi, attr_x_lo}, a sprite is horizontally in range when X <= 256 (X = 256 counts as in range), or when X > 256 and X + width > 512.
- R7: Sprites that pass both tests are listed in ascending index order. Entry k sits at `idx_list[7k+6:7k]`, and `hit_count` gives the number of valid entries.
- R8: Once 32 sprites are listed, further in-range sprites set `overflow` and are not recorded, and `hit_count` stays at 32. Exactly 32 hits leaves `overflow` at 0.
- R9: A `line_start` that arrives during a scan is ignored: the timing and the results of the scan do not change.
- R10: A new scan clears `hit_count` and `overflow` left over from the previous line.
- R11: Between scans `attr_addr` holds at 127, the last sprite evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | Start a scan for `line_num` |
| line_num | input | 8 | Current scanline |
| cfg_small_h | input | 7 | Height/width in pixels for size select 0 |
| cfg_big_h | input | 7 | Height/width in pixels for size select 1 |
| attr_addr | output | 7 | Index of the sprite currently being read |
| attr_x_lo | input | 8 | X bits 7:0 of the addressed sprite |
| attr_y | input | 8 | Y of the addressed sprite |
| attr_x_hi | input | 1 | X bit 8 of the addressed sprite |
| attr_size | input | 1 | Size select of the addressed sprite |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-clock end-of-scan strobe |
| hit_count | output | 6 | Number of listed sprites, 0 to 32 |
| overflow | output | 1 | More than 32 sprites were in range |
| idx_list | output | 224 | 32 packed 7-bit sprite indices |

## Verification
One table state has no sprites in range except a few placed on the horizontal edges: X = 256, X = 257, and negative X one pixel inside or outside the left border for both sizes. This separates the horizontal rule from the vertical one. A second state places sprites one row inside and one row outside each height, plus one that wraps across line 0, to check the modulo vertical test and the size select. A table where every sprite hits, and one where exactly the last 32 hit on line 255, separate overflow from a full list that did not overflow. A scan with a stray start pulse in the middle, run after the overflow scan, shows that mid-scan starts are ignored and that old results are cleared.

// File: rtl/sev_pkg.sv
// Shared definitions for the sprite range evaluator.
// Assumes an 8-bit line/Y space and a 9-bit X space.
package sev_pkg;
    localparam int POS_W = 8;   // line and Y width
    localparam int HGT_W = 7;   // programmable sprite height width

    // Per-sprite attributes needed for the range test
    typedef struct packed {
        logic [POS_W:0]   x;    // 9-bit X
        logic [POS_W-1:0] y;
        logic             big;  // size select
    } spr_attr_t;
endpackage

// File: rtl/sev_scan_ctrl.sv
// Scan sequencer: steps a sprite index through 0..NUM_SPR-1, holding each
// index for CYC_PER_SPR clocks, and flags the evaluation clock of each sprite.
// Assumes CYC_PER_SPR >= 2. Starts are ignored while busy.
module sev_scan_ctrl #(
    parameter int NUM_SPR     = 128,
    parameter int CYC_PER_SPR = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    output logic                       busy_o,
    output logic                       eval_o,
    output logic                       clear_o,
    output logic                       done_o,
    output logic [$clog2(NUM_SPR)-1:0] idx_o
);
    localparam int IDX_W = $clog2(NUM_SPR);
    localparam int PH_W  = (CYC_PER_SPR > 1) ? $clog2(CYC_PER_SPR) : 1;
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CYC_PER_SPR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_SPR - 1);

    logic [PH_W-1:0] ph_q;
    logic            launch;
    logic            last_spr;

    // Decode start acceptance, evaluation clock and last sprite
    always_comb begin
        launch   = start_i && !busy_o;
        eval_o   = busy_o && (ph_q == PH_LAST);
        last_spr = (idx_o == IDX_LAST);
        clear_o  = launch;
    end

    // Advance phase and sprite index; emit done after the last evaluation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            ph_q   <= '0;
            idx_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (launch) begin
                busy_o <= 1'b1;
                ph_q   <= '0;
                idx_o  <= '0;
            end else if (busy_o) begin
                if (eval_o) begin
                    ph_q <= '0;
                    if (last_spr) begin
                        busy_o <= 1'b0;
                        done_o <= 1'b1;
                    end else begin
                        idx_o <= idx_o + 1'b1;
                    end
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sev_range_test.sv
// Combinational in-range test for one sprite against one scanline.
// Vertical: (line - y) mod 256 < height. Horizontal: x <= 256, or x wraps
// negative and x + width > 512. Sprites are square (width = height).
module sev_range_test
    import sev_pkg::*;
(
    input  logic [POS_W-1:0] line_i,
    input  spr_attr_t        attr_i,
    input  logic [HGT_W-1:0] small_h_i,
    input  logic [HGT_W-1:0] big_h_i,
    output logic             hit_o
);
    localparam logic [POS_W:0]   X_EDGE = (POS_W+1)'(1 << POS_W);
    localparam logic [POS_W+1:0] X_WRAP = (POS_W+2)'(2 << POS_W);

    logic [HGT_W-1:0] size_h;
    logic [POS_W-1:0] ydiff;
    logic             v_in;
    logic             h_in;

    // Pick the size, then test both axes
    always_comb begin
        size_h = attr_i.big ? big_h_i : small_h_i;
        ydiff  = line_i - attr_i.y;
        v_in   = ydiff < POS_W'(size_h);
        h_in   = (attr_i.x <= X_EDGE) ||
                 (((POS_W+2)'(attr_i.x) + (POS_W+2)'(size_h)) > X_WRAP);
        hit_o  = v_in && h_in;
    end
endmodule

// File: rtl/sev_index_list.sv
// Index list: records up to DEPTH sprite indices in arrival order, counts
// them, and flags overflow when a hit arrives with the list full.
module sev_index_list #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic                         rec_i,
    input  logic [IDX_W-1:0]             idx_i,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         ovf_o,
    output logic [DEPTH*IDX_W-1:0]       list_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic full;

    // List is full when every slot holds an index
    always_comb full = (count_o == CNT_FULL);

    // Count hits and raise overflow on a hit with no free slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            ovf_o   <= 1'b0;
        end else if (clear_i) begin
            count_o <= '0;
            ovf_o   <= 1'b0;
        end else if (rec_i) begin
            if (full) ovf_o <= 1'b1;
            else      count_o <= count_o + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : gen_slot
        logic [IDX_W-1:0] ent_q;

        // Store the index in slot g when it is the next free slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q <= '0;
            else if (rec_i && !clear_i && !full && count_o == CNT_W'(g))
                ent_q <= idx_i;
        end

        assign list_o[g*IDX_W +: IDX_W] = ent_q;
    end
endmodule

// File: rtl/sev_range_eval.sv
// Top of the sprite scanline range evaluator. Drives the attribute-memory
// address through all sprites, tests each against the line and lists the
// indices of sprites in range. Assumes an asynchronous-read attribute memory.
module sev_range_eval
    import sev_pkg::*;
#(
    parameter int NUM_SPR     = 128,
    parameter int LIST_DEPTH  = 32,
    parameter int CYC_PER_SPR = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     line_start,
    input  logic [7:0]                               line_num,
    input  logic [6:0]                               cfg_small_h,
    input  logic [6:0]                               cfg_big_h,
    output logic [$clog2(NUM_SPR)-1:0]               attr_addr,
    input  logic [7:0]                               attr_x_lo,
    input  logic [7:0]                               attr_y,
    input  logic                                     attr_x_hi,
    input  logic                                     attr_size,
    output logic                                     busy,
    output logic                                     done,
    output logic [$clog2(LIST_DEPTH+1)-1:0]          hit_count,
    output logic                                     overflow,
    output logic [LIST_DEPTH*$clog2(NUM_SPR)-1:0]    idx_list
);
    localparam int IDX_W = $clog2(NUM_SPR);

    logic      scan_eval;
    logic      scan_clear;
    logic      spr_hit;
    spr_attr_t spr_attr;

    // Assemble the sprite attributes from the memory read-back
    always_comb begin
        spr_attr.x   = {attr_x_hi, attr_x_lo};
        spr_attr.y   = attr_y;
        spr_attr.big = attr_size;
    end

    sev_scan_ctrl #(
        .NUM_SPR    (NUM_SPR),
        .CYC_PER_SPR(CYC_PER_SPR)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(line_start),
        .busy_o (busy),
        .eval_o (scan_eval),
        .clear_o(scan_clear),
        .done_o (done),
        .idx_o  (attr_addr)
    );

    sev_range_test u_test (
        .line_i   (line_num),
        .attr_i   (spr_attr),
        .small_h_i(cfg_small_h),
        .big_h_i  (cfg_big_h),
        .hit_o    (spr_hit)
    );

    sev_index_list #(
        .DEPTH(LIST_DEPTH),
        .IDX_W(IDX_W)
    ) u_list (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(scan_clear),
        .rec_i  (scan_eval && spr_hit),
        .idx_i  (attr_addr),
        .count_o(hit_count),
        .ovf_o  (overflow),
        .list_o (idx_list)
    );
endmodule

// File: rtl/sev_eval_chk.sv
// Protocol checker for sev_range_eval, attached with bind.
module sev_eval_chk #(
    parameter int NUM_SPR    = 128,
    parameter int LIST_DEPTH = 32
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               line_start,
    input logic                               busy,
    input logic                               done,
    input logic                               eval,
    input logic [$clog2(NUM_SPR)-1:0]         attr_addr,
    input logic [$clog2(LIST_DEPTH+1)-1:0]    hit_count,
    input logic                               overflow
);
    localparam int IDX_W = $clog2(NUM_SPR);
    localparam int CNT_W = $clog2(LIST_DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SPR - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(LIST_DEPTH);

    // R2: address advances by one after each non-final evaluation
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eval && attr_addr != LAST) |=> attr_addr == $past(attr_addr) + 1'b1);

    // R2: address is held on the non-evaluation clock of a sprite
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eval) |=> $stable(attr_addr));

    // R3: done is a single-clock strobe while idle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: count never exceeds the list depth
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= FULL);

    // R8: overflow only with a full list
    p_ovf_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> hit_count == FULL);

    // R9: a start during a scan neither ends it nor clears the count
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && line_start && !eval) |=> (busy && hit_count >= $past(hit_count)));

    // R11: address holds while idle
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !line_start) |=> $stable(attr_addr));
endmodule

bind sev_range_eval sev_eval_chk #(
    .NUM_SPR   (NUM_SPR),
    .LIST_DEPTH(LIST_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .busy      (busy),
    .done      (done),
    .eval      (scan_eval),
    .attr_addr (attr_addr),
    .hit_count (hit_count),
    .overflow  (overflow)
);

// File: tb/sev_range_eval_tb.sv
module sev_range_eval_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_start = 1'b0;
    logic [7:0]   line_num = '0;
    logic [6:0]   cfg_small_h = 7'd8;
    logic [6:0]   cfg_big_h = 7'd16;
    logic [6:0]   attr_addr;
    logic [7:0]   attr_x_lo;
    logic [7:0]   attr_y;
    logic         attr_x_hi;
    logic         attr_size;
    logic         busy;
    logic         done;
    logic [5:0]   hit_count;
    logic         overflow;
    logic [223:0] idx_list;

    logic [8:0] mem_x [128];
    logic [7:0] mem_y [128];
    logic       mem_b [128];

    int n_chk = 0;
    int n_fail = 0;
    int exp_idx [32];
    int exp_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Attribute memory model with asynchronous read
    always_comb begin
        attr_x_lo = mem_x[attr_addr][7:0];
        attr_x_hi = mem_x[attr_addr][8];
        attr_y    = mem_y[attr_addr];
        attr_size = mem_b[attr_addr];
    end

    sev_range_eval u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
        .cfg_small_h(cfg_small_h), .cfg_big_h(cfg_big_h), .attr_addr(attr_addr),
        .attr_x_lo(attr_x_lo), .attr_y(attr_y), .attr_x_hi(attr_x_hi),
        .attr_size(attr_size), .busy(busy), .done(done), .hit_count(hit_count),
        .overflow(overflow), .idx_list(idx_list)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] y);
        for (int i = 0; i < 128; i++) begin
            mem_x[i] = 9'd0; mem_y[i] = y; mem_b[i] = 1'b0;
        end
    endtask

    // Run one scan, checking address trace, busy and done timing (R2 R3 R9)
    task automatic run_line(input logic [7:0] ln, input bit inject);
        int bad_addr = 0;
        int bad_done = 0;
        int bad_busy = 0;
        @(negedge clk);
        line_num = ln; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int c = 0; c < 258; c++) begin
            if (c > 0) @(negedge clk);
            if (attr_addr != ((c < 256) ? c / 2 : 127)) bad_addr++;
            if (done != (c == 256)) bad_done++;
            if (busy != (c < 256)) bad_busy++;
            if (inject) line_start = (c == 40);
        end
        line_start = 1'b0;
        chk(bad_addr == 0, "R2 address trace mismatches", bad_addr, 0);
        chk(bad_busy == 0, "R2 busy window mismatches", bad_busy, 0);
        chk(bad_done == 0, "R3 done timing mismatches", bad_done, 0);
    endtask

    task automatic check_list(input string req, input bit exp_ovf);
        chk(hit_count == exp_n, {req, " R7 count"}, hit_count, exp_n);
        chk(overflow == exp_ovf, {req, " R8 overflow"}, overflow, exp_ovf);
        for (int k = 0; k < exp_n; k++)
            chk(idx_list[k*7 +: 7] == exp_idx[k], {req, " R7 entry"},
                idx_list[k*7 +: 7], exp_idx[k]);
    endtask

    task automatic t_reset;
        chk(busy == 0 && done == 0, "R1 busy/done after reset", {busy, done}, 0);
        chk(hit_count == 0 && overflow == 0, "R1 count/overflow after reset",
            {overflow, hit_count}, 0);
        chk(attr_addr == 0, "R1 address after reset", attr_addr, 0);
    endtask

    // Horizontal edges on line 10 (R6, R5 for width)
    task automatic t_horizontal;
        fill(8'd200);
        mem_x[5] = 9'd256; mem_y[5] = 8'd10;                  // in
        mem_x[6] = 9'd257; mem_y[6] = 8'd10;                  // out
        mem_x[7] = 9'd505; mem_y[7] = 8'd10;                  // 513 > 512 in
        mem_x[8] = 9'd504; mem_y[8] = 8'd10;                  // 512 out
        mem_x[9] = 9'd504; mem_y[9] = 8'd10; mem_b[9] = 1'b1; // 520 in (R5)
        run_line(8'd10, 1'b0);
        exp_n = 3; exp_idx[0] = 5; exp_idx[1] = 7; exp_idx[2] = 9;
        check_list("R6 horizontal", 1'b0);
    endtask

    // Vertical extents on line 20 and wrap on line 2 (R4, R5)
    task automatic t_vertical;
        fill(8'd100);
        mem_y[3]  = 8'd13;                    // diff 7 in
        mem_y[4]  = 8'd12;                    // diff 8 out
        mem_y[10] = 8'd5;  mem_b[10] = 1'b1;  // diff 15 big in
        mem_y[11] = 8'd4;  mem_b[11] = 1'b1;  // diff 16 big out
        mem_y[12] = 8'd21;                    // diff 255 out
        run_line(8'd20, 1'b0);
        exp_n = 2; exp_idx[0] = 3; exp_idx[1] = 10;
        check_list("R4 R5 vertical", 1'b0);
        fill(8'd100);
        mem_y[70] = 8'd250; mem_b[70] = 1'b1; // diff 8 < 16 in
        mem_y[71] = 8'd250;                   // diff 8 small out
        run_line(8'd2, 1'b0);
        exp_n = 1; exp_idx[0] = 70;
        check_list("R4 wrap", 1'b0);
    endtask

    // Every sprite in range: first 32 kept, overflow set (R8)
    task automatic t_overflow;
        fill(8'd50);
        run_line(8'd50, 1'b0);
        exp_n = 32;
        for (int k = 0; k < 32; k++) exp_idx[k] = k;
        check_list("R8 overflow", 1'b1);
    endtask

    // Stray start mid-scan, also clears previous results (R9 R10)
    task automatic t_ignore_and_clear;
        fill(8'd200);
        mem_y[100] = 8'd30;
        run_line(8'd30, 1'b1);
        exp_n = 1; exp_idx[0] = 100;
        check_list("R9 R10 ignore/clear", 1'b0);
    endtask

    // Exactly 32 hits on the last line: full, no overflow (R8)
    task automatic t_exact_full;
        fill(8'd0);
        for (int i = 96; i < 128; i++) mem_y[i] = 8'd255;
        run_line(8'd255, 1'b0);
        exp_n = 32;
        for (int k = 0; k < 32; k++) exp_idx[k] = 96 + k;
        check_list("R8 exact full", 1'b0);
    endtask

    // Address holds at 127 while idle (R11)
    task automatic t_idle_hold;
        int bad = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (attr_addr != 7'd127 || busy) bad++;
        end
        chk(bad == 0, "R11 idle address hold", bad, 0);
    endtask

    initial begin
        fill(8'd200);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_horizontal();
        t_vertical();
        t_overflow();
        t_ignore_and_clear();
        t_exact_full();
        t_idle_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule